// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Unit (Processor Side)

This block is the processor-side end of a vectored interrupt handshake with an external interrupt controller. When the controller drives the active-low request line LOW, the unit decides whether the pending exception is a normal interrupt or a fast one. For a normal interrupt it raises a registered acknowledge and waits for the controller's address-valid strobe. It then captures the vector address, drops the acknowledge and presents the captured vector to the core with a single-cycle ready pulse.

The handshake has four phases. After the capture, the request line is not looked at again until the controller has taken address-valid LOW. A request level left over from the finished interrupt therefore cannot start a second entry.

The request and address-valid inputs can come from another clock domain. They pass through a chain of `SYNC_STAGES` flops. A depth of 1 gives the single-register path used when the two sides share a clock. The vector bus is not synchronized: it is only read while the synchronized valid is HIGH, and the controller holds the bus stable for that whole time.

The vector leaves as a stream word on `vec_ready`/`vec_out`. There is no ready input, so the core cannot apply back-pressure: it must take the word in the cycle `vec_ready` is HIGH. `vec_out` keeps that word until the next capture.

Top module: `vic_ack_unit`

## Requirements
- R1: After reset, `irq_ack` and `vec_ready` are LOW and `vec_out` is zero.
- R2: While `irq_mask` is HIGH, a LOW request never leads to `irq_ack` being asserted.
- R3: If `fiq_pending` is HIGH during the decision cycle, the unit returns to idle without asserting `irq_ack`. With the request held LOW and `fiq_pending` held HIGH, `irq_ack` stays LOW.
- R4: When the request is seen LOW, `irq_mask` is LOW and `fiq_pending` is LOW, `irq_ack` rises. It then stays HIGH until address-valid is seen HIGH.
- R5: `vec_out` takes the value of `vec_addr_in` in the cycle address-valid is first seen HIGH. Changes on `vec_addr_in` before that cycle are not captured. Changes after it leave `vec_out` unchanged until the next capture.
- R6: `vec_ready` is HIGH for exactly one cycle per capture, in the same cycle the new vector first appears on `vec_out`.
- R7: `irq_ack` is LOW in the cycle `vec_ready` is HIGH, which is the cycle after address-valid is first seen HIGH.
- R8: After a capture, the request line is ignored for as long as address-valid is seen HIGH. A request held LOW during that time does not raise `irq_ack`.
- R9: `irq_req_n` and `addr_valid` each pass through `SYNC_STAGES` flops before the state machine sees them. The request chain resets to HIGH and the valid chain resets to LOW.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_n | input | 1 | Interrupt request from the controller, active LOW, may be asynchronous |
| addr_valid | input | 1 | Vector address valid strobe from the controller, may be asynchronous |
| vec_addr_in | input | VEC_W | Vector address bus from the controller |
| fiq_pending | input | 1 | A fast interrupt is pending; it takes precedence over the normal one |
| irq_mask | input | 1 | HIGH holds the unit in idle |
| irq_ack | output | 1 | Registered acknowledge to the controller |
| vec_ready | output | 1 | One-cycle valid for `vec_out`, with no back-pressure |
| vec_out | output | VEC_W | Captured vector address |

## Verification
Full handshakes are run with vectors of all zeros, all ones, alternating bits and a walking bit. The bus carries the inverted value until the strobe arrives, which separates a capture made on the valid cycle from one made too early or too late. In each handshake the request stays LOW while address-valid lingers HIGH, which exposes any re-sampling before valid falls. Long masked and FIQ-pending windows with the request held LOW check that neither path can reach the acknowledge.

// File: rtl/vic_ack_pkg.sv
package vic_ack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DECIDE   = 3'd1,
    ST_ACK      = 3'd2,
    ST_CAPTURE  = 3'd3,
    ST_WAIT_LOW = 3'd4
  } ack_state_t;
endpackage

// File: rtl/vic_ack_sync.sv
module vic_ack_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/vic_ack_fsm.sv
module vic_ack_fsm
  import vic_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_n_s,
  input  logic valid_s,
  input  logic fiq_pending,
  input  logic irq_mask,
  output logic ack_o,
  output logic capture_o,
  output logic ready_o
);
  ack_state_t state, nxt;
  logic ack_q, ready_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:     if (!irq_mask && !req_n_s) nxt = ST_DECIDE;
      ST_DECIDE:   nxt = fiq_pending ? ST_IDLE : ST_ACK;
      ST_ACK:      if (valid_s) nxt = ST_CAPTURE;
      ST_CAPTURE:  nxt = ST_WAIT_LOW;
      ST_WAIT_LOW: if (!valid_s) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  assign capture_o = (state == ST_ACK) && valid_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ack_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state   <= nxt;
      ack_q   <= (nxt == ST_ACK);
      ready_q <= capture_o;
    end
  end

  assign ack_o   = ack_q;
  assign ready_o = ready_q;

  p_mask_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && irq_mask) |=> (state == ST_IDLE && !ack_q));

  p_fiq_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECIDE && fiq_pending) |=> (state == ST_IDLE && !ack_q));

  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_q && !valid_s) |=> ack_q);

  p_ready_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);

  p_ack_low_on_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !ack_q);

  p_no_resample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_LOW && valid_s) |=> (!ack_q && state != ST_DECIDE));
endmodule

// File: rtl/vic_ack_vecreg.sv
module vic_ack_vecreg #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  p_vec_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/vic_ack_unit.sv
module vic_ack_unit #(
  parameter int VEC_W       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_req_n,
  input  logic             addr_valid,
  input  logic [VEC_W-1:0] vec_addr_in,
  input  logic             fiq_pending,
  input  logic             irq_mask,
  output logic             irq_ack,
  output logic             vec_ready,
  output logic [VEC_W-1:0] vec_out
);
  logic req_n_s, valid_s, capture;

  vic_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_req_n), .q(req_n_s));

  vic_ack_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_valid_sync (
    .clk(clk), .rst_n(rst_n), .d(addr_valid), .q(valid_s));

  vic_ack_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_n_s(req_n_s), .valid_s(valid_s),
    .fiq_pending(fiq_pending), .irq_mask(irq_mask),
    .ack_o(irq_ack), .capture_o(capture), .ready_o(vec_ready));

  vic_ack_vecreg #(.W(VEC_W)) u_vec (
    .clk(clk), .rst_n(rst_n), .load(capture), .d(vec_addr_in), .q(vec_out));

  p_ready_new_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_ready) |-> $past(irq_ack));
endmodule

// File: tb/vic_ack_unit_tb.sv
module vic_ack_unit_tb;
  localparam int VW = 30;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_req_n = 1'b1, addr_valid = 1'b0, fiq_pending = 1'b0, irq_mask = 1'b0;
  logic [VW-1:0] vec_addr_in = '0;
  logic irq_ack, vec_ready;
  logic [VW-1:0] vec_out;

  int checks = 0;
  int fails = 0;
  logic [VW-1:0] exp_q[$];
  logic prev_ready = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vic_ack_unit #(.VEC_W(VW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .addr_valid(addr_valid),
    .vec_addr_in(vec_addr_in), .fiq_pending(fiq_pending), .irq_mask(irq_mask),
    .irq_ack(irq_ack), .vec_ready(vec_ready), .vec_out(vec_out));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops scoreboard on each ready pulse (R5, R6, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (vec_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected ready", 64'(vec_out), 0);
        else begin
          logic [VW-1:0] e;
          e = exp_q.pop_front();
          chk(vec_out == e, "R5 captured vector", 64'(vec_out), 64'(e));
        end
        chk(!prev_ready, "R6 single-cycle ready", 64'(prev_ready), 0);
        chk(!irq_ack, "R7 ack low with ready", 64'(irq_ack), 0);
      end
      prev_ready = vec_ready;
    end
  end

  // Emulated controller driving one full handshake
  task automatic do_irq(input logic [VW-1:0] v, input int linger);
    int n;
    @(negedge clk);
    irq_req_n = 1'b0;
    vec_addr_in = ~v;
    n = 0;
    while (!irq_ack && n < 40) begin @(negedge clk); n++; end
    chk(irq_ack, "R4 ack rises", 64'(irq_ack), 1);
    repeat (4) @(negedge clk);
    chk(irq_ack, "R4 ack held until valid", 64'(irq_ack), 1);
    vec_addr_in = v;
    exp_q.push_back(v);
    addr_valid = 1'b1;
    n = 0;
    while (irq_ack && n < 20) begin @(negedge clk); n++; end
    chk(!irq_ack, "R7 ack drops after valid", 64'(irq_ack), 0);
    @(negedge clk);
    vec_addr_in = ~v;
    for (int i = 0; i < linger; i++) begin
      @(negedge clk);
      chk(!irq_ack, "R8 stale request ignored", 64'(irq_ack), 0);
    end
    chk(vec_out == v, "R5 vector held after bus change", 64'(vec_out), 64'(v));
    irq_req_n = 1'b1;
    addr_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(!irq_ack, "R8 no retrigger after release", 64'(irq_ack), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(!irq_ack, "R1 reset ack", 64'(irq_ack), 0);
    chk(!vec_ready, "R1 reset ready", 64'(vec_ready), 0);
    chk(vec_out == '0, "R1 reset vector", 64'(vec_out), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!irq_ack, "R9 idle after reset with request high", 64'(irq_ack), 0);

    // R2 mask
    irq_mask = 1'b1;
    irq_req_n = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(!irq_ack, "R2 masked", 64'(irq_ack), 0);
    end
    irq_req_n = 1'b1;
    repeat (4) @(negedge clk);
    irq_mask = 1'b0;

    // R3 FIQ pending
    fiq_pending = 1'b1;
    irq_req_n = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk(!irq_ack, "R3 fiq abort", 64'(irq_ack), 0);
    end
    irq_req_n = 1'b1;
    repeat (4) @(negedge clk);
    fiq_pending = 1'b0;
    repeat (2) @(negedge clk);

    do_irq('0, 6);
    do_irq('1, 10);
    do_irq({15{2'b10}}, 3);
    for (int b = 0; b < VW; b += 7) do_irq(VW'(1) << b, 5);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R6 every capture produced ready", 64'(exp_q.size()), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule